// File: doc/BRIEF.md
# Same-ID Ordering Stall Gate

This block guards one direction (read or write) of an interconnect path that fans one upstream port out to several downstream targets. It keeps a small table of the requests already issued and not yet answered. Each table entry holds the request ID, the target index, the byte range the burst covers, and whether the request is a Device or a Normal access. From that table the block decides, in the same cycle, whether a new address-channel request may go ahead (`req_ready` high) or must wait. It does not route, buffer, or touch data.

Two kinds of hazard hold a request back. The first is a same-ID request already outstanding at a different target, because the two targets could answer out of order. The second is a Device request whose bytes overlap an outstanding Device request with another ID. Same-ID requests to the same target go ahead, because the single downstream path keeps their order. The ID compared is the full ID the block receives, so any upstream-port identity folded into the high ID bits keeps the rules separate for each upstream port.

An entry is freed by the last response beat of its transaction. The response side reports `rsp_fire` with `rsp_last`. For writes `rsp_last` is tied high. Within one ID the oldest entry is freed first.

Top module: `axi_order_gate`

## Requirements
- R1: After reset the table is empty, so any request is accepted on the first cycle it is presented.
- R2: A request is Device when cache bits [3:1] are all zero (cache values 0000 and 0001). Any other value is Normal.
- R3: A request is stalled while an outstanding entry has the same ID and a different target index.
- R4: A request whose ID is outstanding only at the same target is accepted, whatever its memory type and address.
- R5: A Device request is stalled while an outstanding Device entry with a different ID covers at least one of its bytes. It is accepted when no byte is shared.
- R6: Requests with different IDs whose ranges overlap are accepted when at least one of the two is Normal.
- R7: The byte range is computed from the burst type. Burst type 00 (fixed) covers one beat of 2^size bytes from the address. Burst type 01 (incrementing) covers (len+1)·2^size bytes from the address. Burst type 10 (wrapping) covers the (len+1)·2^size window aligned down to that total. Range ends are inclusive.
- R8: With all DEPTH (default 8) entries in use, every request is stalled. A retirement makes room again.
- R9: `rsp_fire` with `rsp_last` high frees the oldest entry of `rsp_id`. With `rsp_last` low, or with no entry for that ID, nothing changes.
- R10: IDs are compared on every bit, so IDs that differ only in the top bit (upstream port identity) are independent.
- R11: A request is entered into the table exactly on a cycle with `req_valid` and `req_ready` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Address-channel request present |
| req_ready | output | 1 | Request may issue this cycle |
| req_id | input | IDW | Full request ID, upstream port bits included |
| req_slave | input | SLW | Target index |
| req_addr | input | AW | Start byte address |
| req_len | input | 8 | Beats minus one |
| req_size | input | 3 | Log2 of bytes per beat |
| req_burst | input | 2 | 00 fixed, 01 incrementing, 10 wrapping |
| req_cache | input | 4 | Memory attribute bits |
| rsp_fire | input | 1 | Response beat handshake |
| rsp_last | input | 1 | Final beat of the transaction |
| rsp_id | input | IDW | ID of the response |

## Verification
The bench builds the block with its defaults: IDW=4, SLW=2, AW=32, DEPTH=8. Eight entries are few enough that directed filling reaches the full-table stall, and random traffic fills the table often. Random traffic uses six IDs, four targets and a 256-byte address window, so same-ID cross-target conflicts and Device overlaps across IDs happen often. The 4-bit ID lets a top-bit-only difference stand for two upstream ports.

// File: rtl/axi_ord_pkg.sv
// Package: shared encodings and attribute decode for the ordering gate.
// Assumes the standard burst-type and cache-bit encodings.
package axi_ord_pkg;

    typedef enum logic [1:0] {
        BURST_FIXED = 2'b00,
        BURST_INCR  = 2'b01,
        BURST_WRAP  = 2'b10,
        BURST_RSVD  = 2'b11
    } burst_e;

    // Device when none of the cache bits [3:1] is set.
    function automatic logic cache_is_device(input logic [3:0] cache);
        return (cache[3:1] == 3'b000);
    endfunction

endpackage

// File: rtl/axi_ord_range.sv
// Module: inclusive byte range covered by one burst.
// Assumes incrementing bursts stay within their 4 KB page (no wrap of the
// address space) and that wrapping bursts are legal (2, 4, 8 or 16 beats).
module axi_ord_range #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [7:0]    len,
    input  logic [2:0]    size,
    input  logic [1:0]    burst,
    output logic [AW-1:0] lo,
    output logic [AW-1:0] hi
);
    import axi_ord_pkg::*;

    logic [AW-1:0] beat_bytes;
    logic [AW-1:0] total_bytes;

    // Purpose: size of one beat and of the whole burst in bytes.
    always_comb begin
        beat_bytes  = AW'(1) << size;
        total_bytes = (AW'(len) + AW'(1)) << size;
    end

    // Purpose: pick the range rule that matches the burst type.
    always_comb begin
        case (burst_e'(burst))
            BURST_FIXED: begin
                lo = addr;
                hi = addr + beat_bytes - AW'(1);
            end
            BURST_WRAP: begin
                lo = addr & ~(total_bytes - AW'(1));
                hi = lo + total_bytes - AW'(1);
            end
            default: begin
                lo = addr;
                hi = addr + total_bytes - AW'(1);
            end
        endcase
    end
endmodule

// File: rtl/axi_ord_hazard.sv
// Module: compares one table entry with the incoming request.
// Flags a hazard for a same-ID entry at another target, or for a Device
// entry with another ID whose range shares a byte with a Device request.
module axi_ord_hazard #(
    parameter int IDW = 4,
    parameter int SLW = 2,
    parameter int AW  = 32
) (
    input  logic           e_valid,
    input  logic [IDW-1:0] e_id,
    input  logic [SLW-1:0] e_slave,
    input  logic [AW-1:0]  e_lo,
    input  logic [AW-1:0]  e_hi,
    input  logic           e_dev,
    input  logic [IDW-1:0] r_id,
    input  logic [SLW-1:0] r_slave,
    input  logic [AW-1:0]  r_lo,
    input  logic [AW-1:0]  r_hi,
    input  logic           r_dev,
    output logic           hazard
);
    logic same_id;
    logic overlap;

    // Purpose: evaluate both hazard kinds against this entry.
    always_comb begin
        same_id = (e_id == r_id);
        overlap = (e_lo <= r_hi) && (r_lo <= e_hi);
        hazard  = e_valid &&
                  ((same_id && (e_slave != r_slave)) ||
                   (!same_id && e_dev && r_dev && overlap));
    end
endmodule

// File: rtl/axi_ord_age.sv
// Module: age matrix over the table slots; picks the oldest candidate.
// Row i bit j set means slot j was filled before slot i. Assumes a slot is
// never filled and freed in the same cycle.
module axi_ord_age #(
    parameter int DEPTH = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] valid,
    input  logic             alloc_en,
    input  logic [IW-1:0]    alloc_idx,
    input  logic [DEPTH-1:0] cand,
    output logic [DEPTH-1:0] oldest
);
    logic [DEPTH-1:0] older [DEPTH];

    // Purpose: record that a new slot is younger than every live slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) older[i] <= '0;
        end else if (alloc_en) begin
            older[alloc_idx] <= valid;
            for (int i = 0; i < DEPTH; i++) older[i][alloc_idx] <= 1'b0;
        end
    end

    // Purpose: a candidate is oldest when no older slot is also a candidate.
    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            oldest[i] = cand[i] && ((older[i] & cand) == '0);
    end
endmodule

// File: rtl/axi_order_gate.sv
// Module: same-ID ordering stall gate for one direction of one upstream port.
// Keeps DEPTH outstanding requests and lowers req_ready when issuing the
// presented request could break ordering. Assumes responses of one ID come
// back in issue order, and that rsp_last is tied high on the write side.
module axi_order_gate #(
    parameter int IDW   = 4,
    parameter int SLW   = 2,
    parameter int AW    = 32,
    parameter int DEPTH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [IDW-1:0] req_id,
    input  logic [SLW-1:0] req_slave,
    input  logic [AW-1:0]  req_addr,
    input  logic [7:0]     req_len,
    input  logic [2:0]     req_size,
    input  logic [1:0]     req_burst,
    input  logic [3:0]     req_cache,
    input  logic           rsp_fire,
    input  logic           rsp_last,
    input  logic [IDW-1:0] rsp_id
);
    import axi_ord_pkg::*;

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]          ent_valid;
    logic [DEPTH-1:0][IDW-1:0] ent_id;
    logic [DEPTH-1:0][SLW-1:0] ent_slave;
    logic [DEPTH-1:0][AW-1:0]  ent_lo;
    logic [DEPTH-1:0][AW-1:0]  ent_hi;
    logic [DEPTH-1:0]          ent_dev;

    logic [AW-1:0]    r_lo, r_hi;
    logic             r_dev;
    logic [DEPTH-1:0] hazard;
    logic [DEPTH-1:0] rsp_cand;
    logic [DEPTH-1:0] oldest;
    logic [DEPTH-1:0] retire_vec;
    logic [IW-1:0]    free_idx;
    logic             full;
    logic             alloc;

    axi_ord_range #(.AW(AW)) u_range (
        .addr(req_addr), .len(req_len), .size(req_size), .burst(req_burst),
        .lo(r_lo), .hi(r_hi)
    );

    // Purpose: memory type of the presented request.
    always_comb r_dev = cache_is_device(req_cache);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        axi_ord_hazard #(.IDW(IDW), .SLW(SLW), .AW(AW)) u_hz (
            .e_valid(ent_valid[g]), .e_id(ent_id[g]), .e_slave(ent_slave[g]),
            .e_lo(ent_lo[g]), .e_hi(ent_hi[g]), .e_dev(ent_dev[g]),
            .r_id(req_id), .r_slave(req_slave), .r_lo(r_lo), .r_hi(r_hi),
            .r_dev(r_dev), .hazard(hazard[g])
        );
    end

    // Purpose: lowest free slot and table-full flag.
    always_comb begin
        free_idx = '0;
        full     = 1'b1;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                free_idx = IW'(i);
                full     = 1'b0;
            end
        end
    end

    // Purpose: issue decision and allocation strobe.
    always_comb begin
        req_ready = !full && (hazard == '0);
        alloc     = req_valid && req_ready;
    end

    // Purpose: slots holding the ID named by the response.
    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            rsp_cand[i] = ent_valid[i] && (ent_id[i] == rsp_id);
    end

    axi_ord_age #(.DEPTH(DEPTH)) u_age (
        .clk(clk), .rst_n(rst_n), .valid(ent_valid), .alloc_en(alloc),
        .alloc_idx(free_idx), .cand(rsp_cand), .oldest(oldest)
    );

    // Purpose: the last response beat frees the oldest slot of its ID.
    always_comb retire_vec = (rsp_fire && rsp_last) ? oldest : '0;

    // Purpose: table update on issue and retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_id    <= '0;
            ent_slave <= '0;
            ent_lo    <= '0;
            ent_hi    <= '0;
            ent_dev   <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (retire_vec[i]) ent_valid[i] <= 1'b0;
                if (alloc && (free_idx == IW'(i))) begin
                    ent_valid[i] <= 1'b1;
                    ent_id[i]    <= req_id;
                    ent_slave[i] <= req_slave;
                    ent_lo[i]    <= r_lo;
                    ent_hi[i]    <= r_hi;
                    ent_dev[i]   <= r_dev;
                end
            end
        end
    end
endmodule

// File: rtl/axi_order_gate_chk.sv
// Checker: temporal properties of the ordering gate, bound to its top.
module axi_order_gate_chk #(
    parameter int IDW   = 4,
    parameter int SLW   = 2,
    parameter int DEPTH = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic                      req_ready,
    input logic [IDW-1:0]            req_id,
    input logic [SLW-1:0]            req_slave,
    input logic                      rsp_fire,
    input logic                      rsp_last,
    input logic [IDW-1:0]            rsp_id,
    input logic [DEPTH-1:0]          ent_valid,
    input logic [DEPTH-1:0][IDW-1:0] ent_id,
    input logic [DEPTH-1:0][SLW-1:0] ent_slave
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          cross_slave;
    logic          id_present;
    logic [CW-1:0] occ;
    logic          issued;
    logic          freed;

    // Purpose: observations drawn from the table for the properties.
    always_comb begin
        cross_slave = 1'b0;
        id_present  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_valid[i] && ent_id[i] == req_id && ent_slave[i] != req_slave)
                cross_slave = 1'b1;
            if (ent_valid[i] && ent_id[i] == rsp_id)
                id_present = 1'b1;
        end
        occ    = CW'($countones(ent_valid));
        issued = req_valid && req_ready;
        freed  = rsp_fire && rsp_last && id_present;
    end

    assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ent_valid == '0));

    assert_cross_slave_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cross_slave |-> !req_ready);

    assert_full_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (&ent_valid) |-> !req_ready);

    assert_retire_shrinks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (freed && !issued) |=> (occ == $past(occ) - CW'(1)));

    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!freed && !issued) |=> $stable(ent_valid));

    assert_issue_grows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (issued && !freed) |=> (occ == $past(occ) + CW'(1)));
endmodule

bind axi_order_gate axi_order_gate_chk #(.IDW(IDW), .SLW(SLW), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_slave(req_slave), .rsp_fire(rsp_fire),
    .rsp_last(rsp_last), .rsp_id(rsp_id), .ent_valid(ent_valid),
    .ent_id(ent_id), .ent_slave(ent_slave)
);

// File: tb/axi_order_gate_bench.sv
// Bench: directed corner cases, then seeded random traffic, checked
// against a reference table kept by bench functions.
module axi_order_gate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int IDW = 4, SLW = 2, AW = 32, DEPTH = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [IDW-1:0] req_id = '0;
    logic [SLW-1:0] req_slave = '0;
    logic [AW-1:0]  req_addr = '0;
    logic [7:0]     req_len = '0;
    logic [2:0]     req_size = '0;
    logic [1:0]     req_burst = 2'b01;
    logic [3:0]     req_cache = 4'b0010;
    logic           rsp_fire = 1'b0;
    logic           rsp_last = 1'b0;
    logic [IDW-1:0] rsp_id = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference table
    bit          m_valid [DEPTH];
    int unsigned m_id [DEPTH], m_slave [DEPTH], m_lo [DEPTH], m_hi [DEPTH];
    bit          m_dev [DEPTH];
    int unsigned m_stamp [DEPTH];
    int unsigned stamp = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    axi_order_gate #(.IDW(IDW), .SLW(SLW), .AW(AW), .DEPTH(DEPTH)) u_axi_order_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_id(req_id), .req_slave(req_slave), .req_addr(req_addr),
        .req_len(req_len), .req_size(req_size), .req_burst(req_burst),
        .req_cache(req_cache), .rsp_fire(rsp_fire), .rsp_last(rsp_last),
        .rsp_id(rsp_id)
    );

    function automatic bit f_dev(input logic [3:0] c);
        return (c[3] | c[2] | c[1]) == 1'b0;
    endfunction

    function automatic void f_range(input int unsigned a, input int unsigned len,
                                    input int unsigned sz, input int unsigned b,
                                    output int unsigned lo, output int unsigned hi);
        int unsigned beat, tot;
        beat = 1 << sz;
        tot  = (len + 1) * beat;
        if (b == 0) begin lo = a; hi = a + beat - 1; end
        else if (b == 2) begin lo = a - (a % tot); hi = lo + tot - 1; end
        else begin lo = a; hi = a + tot - 1; end
    endfunction

    function automatic bit f_ready();
        int unsigned lo, hi, used;
        bit rd;
        f_range(req_addr, req_len, req_size, req_burst, lo, hi);
        rd = f_dev(req_cache);
        used = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!m_valid[i]) continue;
            used++;
            if (m_id[i] == req_id && m_slave[i] != req_slave) return 1'b0;
            if (m_id[i] != req_id && m_dev[i] && rd && m_lo[i] <= hi && lo <= m_hi[i])
                return 1'b0;
        end
        return used < DEPTH;
    endfunction

    task automatic check(input bit got, input bit exp, input string tag);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: req_ready=%0b expected %0b", tag, got, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check ready, update the model.
    task automatic step(input bit v, input int id, input int sl, input int unsigned a,
                        input int len, input int sz, input int b, input logic [3:0] c,
                        input bit rf, input bit rl, input int rid,
                        input int want, input string tag);
        bit exp, got;
        int unsigned lo, hi;
        int best;
        @(negedge clk);
        req_valid = v; req_id = IDW'(id); req_slave = SLW'(sl); req_addr = a;
        req_len = 8'(len); req_size = 3'(sz); req_burst = 2'(b); req_cache = c;
        rsp_fire = rf; rsp_last = rl; rsp_id = IDW'(rid);
        #1;
        got = req_ready;
        exp = f_ready();
        check(got, exp, {tag, " (model)"});
        if (want >= 0) check(got, want[0], tag);
        @(posedge clk);
        // retire oldest of rsp_id
        if (rf && rl) begin
            best = -1;
            for (int i = 0; i < DEPTH; i++)
                if (m_valid[i] && m_id[i] == rid && (best < 0 || m_stamp[i] < m_stamp[best]))
                    best = i;
            if (best >= 0) m_valid[best] = 1'b0;
        end
        if (v && exp) begin
            f_range(a, len, sz, b, lo, hi);
            for (int i = 0; i < DEPTH; i++) begin
                if (!m_valid[i]) begin
                    m_valid[i] = 1'b1; m_id[i] = id; m_slave[i] = sl;
                    m_lo[i] = lo; m_hi[i] = hi; m_dev[i] = f_dev(c);
                    m_stamp[i] = stamp++;
                    break;
                end
            end
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed, a;
        int len, sz, b, rid, k;
        logic [3:0] c;
        bit rf;
        for (int i = 0; i < DEPTH; i++) m_valid[i] = 1'b0;
        seed = $urandom(32'h5EED_0107);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: empty table accepts the first request (id1, target 0, Normal 0x100..0x10F)
        step(1, 1, 0, 32'h100, 3, 2, 1, 4'b0010, 0, 0, 0, 1, "R1 first request accepted");
        // R3: same ID, other target
        step(1, 1, 1, 32'h100, 0, 0, 1, 4'b0010, 0, 0, 0, 0, "R3 same id other slave stalls");
        // R4: same ID, same target, Device 0x800..0x803
        step(1, 1, 0, 32'h800, 0, 2, 0, 4'b0000, 0, 0, 0, 1, "R4 same id same slave accepted");
        // R5, R2: cache 0001 is Device, byte 0x803 overlaps
        step(0, 2, 2, 32'h803, 0, 0, 0, 4'b0001, 0, 0, 0, 0, "R5 R2 device overlap other id stalls");
        // R5: adjacent byte 0x804 does not overlap
        step(0, 2, 2, 32'h804, 0, 0, 0, 4'b0000, 0, 0, 0, 1, "R5 device adjacent accepted");
        // R6, R2: cache 0010 is Normal
        step(0, 2, 2, 32'h800, 0, 2, 1, 4'b0010, 0, 0, 0, 1, "R6 R2 normal overlap accepted");
        // R10: id 9 differs from id 1 only in the top bit
        step(0, 9, 1, 32'h000, 0, 0, 1, 4'b0010, 0, 0, 0, 1, "R10 top id bit distinct");
        // R7: wrap 0x7F8, 2x8 bytes -> 0x7F0..0x7FF, no overlap
        step(0, 3, 2, 32'h7F8, 1, 3, 2, 4'b0000, 0, 0, 0, 1, "R7 wrap below boundary accepted");
        // R7: wrap 0x808 -> 0x800..0x80F overlaps
        step(0, 3, 2, 32'h808, 1, 3, 2, 4'b0000, 0, 0, 0, 0, "R7 wrap aligned window stalls");
        // R7: incr 0x7FC one 8-byte beat -> 0x7FC..0x803 overlaps
        step(0, 3, 2, 32'h7FC, 0, 3, 1, 4'b0000, 0, 0, 0, 0, "R7 incr crossing stalls");
        // R7: fixed 0x7FC, 4 beats of 4 bytes -> 0x7FC..0x7FF only
        step(0, 3, 2, 32'h7FC, 3, 2, 0, 4'b0000, 0, 0, 0, 1, "R7 fixed single beat accepted");
        // R9: non-last beat frees nothing
        step(0, 1, 1, 32'h0, 0, 0, 1, 4'b0010, 1, 0, 1, 0, "R9 non-last beat no retire");
        step(0, 1, 1, 32'h0, 0, 0, 1, 4'b0010, 1, 1, 1, 0, "R9 before first retire");
        // R9: one id1 entry still present; the Device one (0x800) remains or not
        step(0, 1, 1, 32'h0, 0, 0, 1, 4'b0010, 0, 0, 0, 0, "R9 one entry left stalls");
        // R9: oldest (Normal) freed first, so Device 0x800 still blocks id2
        step(0, 2, 2, 32'h800, 0, 0, 0, 4'b0000, 1, 1, 1, 0, "R9 oldest freed first");
        step(0, 1, 1, 32'h0, 0, 0, 1, 4'b0010, 0, 0, 0, 1, "R9 all retired accepted");
        // R9: stray response id 7 with empty table
        step(0, 7, 0, 32'h0, 0, 0, 1, 4'b0010, 1, 1, 7, 1, "R9 stray response no effect");
        // R11/R8: fill eight slots
        for (int i = 0; i < DEPTH; i++)
            step(1, i, 0, 32'h1000 + i * 64, 0, 2, 1, 4'b0010, 0, 0, 0, 1, "R11 fill slot accepted");
        step(1, 8, 3, 32'h9000, 0, 0, 1, 4'b0010, 0, 0, 0, 0, "R8 full table stalls");
        step(0, 8, 3, 32'h9000, 0, 0, 1, 4'b0010, 1, 1, 3, 0, "R8 still full before retire");
        step(0, 8, 3, 32'h9000, 0, 0, 1, 4'b0010, 0, 0, 0, 1, "R8 room after retire");
        // R11: request not presented is not entered; id8 target 3 absent
        step(0, 8, 0, 32'h9000, 0, 0, 1, 4'b0010, 0, 0, 0, 1, "R11 no valid no entry");
        for (int i = 0; i < DEPTH; i++)
            step(0, 0, 0, 0, 0, 0, 1, 4'b0010, 1, 1, i, -1, "R9 drain");

        // Random phase: covers R3, R4, R5, R6, R8 against the model
        for (int n = 0; n < 3000; n++) begin
            sz = $urandom_range(0, 2);
            b  = $urandom_range(0, 2);
            len = (b == 2) ? (($urandom_range(0, 1) == 1) ? 3 : 1) : $urandom_range(0, 3);
            a  = $urandom_range(0, 255) & ~((1 << sz) - 1);
            c  = ($urandom_range(0, 1) == 1) ? 4'($urandom_range(0, 1)) : 4'($urandom_range(2, 15));
            rf = ($urandom_range(0, 2) == 0);
            rid = $urandom_range(0, 5);
            k = $urandom_range(0, DEPTH - 1);
            if (m_valid[k] && $urandom_range(0, 3) != 0) rid = int'(m_id[k]);
            step($urandom_range(0, 3) != 0, $urandom_range(0, 5), $urandom_range(0, 3), a,
                 len, sz, b, c, rf, $urandom_range(0, 3) != 0, rid, -1, "R3 R5 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule